// File: doc/BRIEF.md
# Speech Block Serial Framer

This block packs two coded speech frames of 137 bits each into a fixed 480-bit transport block. It sends that block as a serial bitstream, one bit for each pulse of a bit-rate enable strobe. At an 8 kbit/s strobe rate, one block lasts 60 ms. Each block opens with a header of 24 zeros and a single one. Five control bits follow the header. After that come the payload bits: first speech frame, 79 spare ones, second speech frame, and 79 more spare ones. From bit 48 of the block onward, every 24th bit is forced to one. Because of this, the payload can never imitate the 24-zero header.

The surrounding logic drives the two frame buffers, a 3-bit steal code, a 2-bit bad-frame code and a call-active flag. The framer samples all of these only on the enable that emits the first header bit. After that sample, the caller may change them while the block is still being sent. While no call is active, the line carries continuous ones. A call can start only between blocks.

Top module: `sblk_framer`

## Requirements
- R1: While no block is in progress (after reset, or after a block ends with `call_active` low), every enable emits a 1 and `block_start` stays low.
- R2: A block is exactly 480 enables long. Once it has started, it runs to its end even if `call_active` drops during the block.
- R3: Block bits 0 to 23 are 0 and bit 24 is 1 (bit 0 is sent first).
- R4: Block bits 25 to 29 carry `steal_code[2]`, `steal_code[1]`, `steal_code[0]`, `bad_code[1]` (bad flag of the first frame) and `bad_code[0]` (bad flag of the second frame), in that order.
- R5: Every block bit at position 48 + 24k, for k = 0 to 17, is 1.
- R6: The payload positions (every position from 30 up that is not a forced one) are filled in order. Payload slots 0 to 136 carry `frame_a[0]` to `frame_a[136]`, with `frame_a[0]` sent first.
- R7: Payload slots 137 to 215 and 353 to 431 are all 1.
- R8: Payload slots 216 to 352 carry `frame_b[0]` to `frame_b[136]`. `frame_b[0]` lands at block bit 255.
- R9: Frame, steal and bad-frame inputs are sampled only on the enable that emits block bit 0. Changes made later in the block have no effect on that block.
- R10: `block_start` is high for exactly one clock cycle, in the cycle after the enable that emits block bit 0, together with that 0 on `ser_out`.
- R11: `ser_out` changes only on clock edges where `bit_en` is high.
- R12: If `call_active` is high on the enable right after block bit 479, the next block's bit 0 is emitted on that enable, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe at the line bit rate |
| call_active | input | 1 | High while a call wants blocks sent |
| frame_a | input | 137 | First speech frame, bit 0 sent first |
| frame_b | input | 137 | Second speech frame, bit 0 sent first |
| steal_code | input | 3 | Steal state of the two frames (C1 = bit 2) |
| bad_code | input | 2 | Bad-frame flags, bit 1 for the first frame |
| ser_out | output | 1 | Registered serial line bit |
| block_start | output | 1 | One-cycle marker with block bit 0 |

## Verification
Two things can fall on the same enable. The last bit of one block is emitted on one enable, and on the very next enable the framer must decide to start again and latch new inputs. The bench provokes this by holding `call_active` high across a run of blocks. It loads the next block's frames and codes while the current block is still at bit 200. It then judges that each following block begins with zero idle enables, and that each block's content matches the inputs present at its own start, not the ones loaded mid-block.

// File: rtl/sblk_pkg.sv
package sblk_pkg;
  typedef enum logic [2:0] {
    BK_HDR0 = 3'd0,
    BK_HDR1 = 3'd1,
    BK_CTRL = 3'd2,
    BK_SYNC = 3'd3,
    BK_PAY  = 3'd4
  } bitkind_e;
endpackage

// File: rtl/sblk_seq.sv
module sblk_seq
  import sblk_pkg::*;
#(
  parameter int BLOCK_BITS  = 480,
  parameter int HDR_ZEROS   = 24,
  parameter int CTRL_BITS   = 5,
  parameter int SYNC_PERIOD = 24,
  parameter int FRAME_BITS  = 137,
  parameter int SPARE_BITS  = 79,
  localparam int POS_W      = $clog2(BLOCK_BITS),
  localparam int PAY_SLOTS  = 2 * (FRAME_BITS + SPARE_BITS),
  localparam int SLOT_W     = $clog2(PAY_SLOTS),
  localparam int PH_W       = $clog2(SYNC_PERIOD),
  localparam int CI_W       = $clog2(CTRL_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              call_active,
  output logic              start,
  output logic              emit,
  output logic              in_block,
  output bitkind_e          kind,
  output logic [CI_W-1:0]   ctrl_idx,
  output logic [SLOT_W-1:0] slot
);
  localparam int PAY_START  = HDR_ZEROS + 1 + CTRL_BITS;
  localparam int SYNC_START = HDR_ZEROS + SYNC_PERIOD;

  logic              active_q;
  logic [POS_W-1:0]  pos_q;
  logic [PH_W-1:0]   ph_q;
  logic [SLOT_W-1:0] slot_q;

  logic [POS_W-1:0]  cur_pos;
  logic [PH_W-1:0]   cur_ph;
  logic [SLOT_W-1:0] cur_slot;
  logic              last_bit;

  // a block that is not running always resumes from position zero
  assign cur_pos  = active_q ? pos_q  : '0;
  assign cur_ph   = active_q ? ph_q   : '0;
  assign cur_slot = active_q ? slot_q : '0;

  assign start    = en && !active_q && call_active;
  assign emit     = en && (active_q || call_active);
  assign in_block = active_q;
  assign slot     = cur_slot;
  assign last_bit = (cur_pos == POS_W'(BLOCK_BITS - 1));
  assign ctrl_idx = CI_W'(cur_pos - POS_W'(HDR_ZEROS + 1));

  always_comb begin
    if (cur_pos < POS_W'(HDR_ZEROS))
      kind = BK_HDR0;
    else if (cur_pos == POS_W'(HDR_ZEROS))
      kind = BK_HDR1;
    else if (cur_pos < POS_W'(PAY_START))
      kind = BK_CTRL;
    else if (cur_pos >= POS_W'(SYNC_START) && cur_ph == '0)
      kind = BK_SYNC;
    else
      kind = BK_PAY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      ph_q     <= '0;
      slot_q   <= '0;
    end else if (emit) begin
      if (last_bit) begin
        active_q <= 1'b0;
        pos_q    <= '0;
        ph_q     <= '0;
        slot_q   <= '0;
      end else begin
        active_q <= 1'b1;
        pos_q    <= cur_pos + POS_W'(1);
        ph_q     <= (cur_ph == PH_W'(SYNC_PERIOD - 1)) ? '0 : cur_ph + PH_W'(1);
        slot_q   <= cur_slot + SLOT_W'(kind == BK_PAY);
      end
    end
  end

  // R2: the final bit of a block is the final payload slot
  assert_slot_total_R2: assert property (@(posedge clk) disable iff (rst)
    (emit && last_bit) |-> (kind == BK_PAY && cur_slot == SLOT_W'(PAY_SLOTS - 1)));

  // R2: the position register never leaves the block
  assert_pos_bound_R2: assert property (@(posedge clk) disable iff (rst)
    pos_q < POS_W'(BLOCK_BITS));
endmodule

// File: rtl/sblk_hold.sv
module sblk_hold #(
  parameter int FRAME_BITS = 137,
  parameter int STEAL_W    = 3,
  parameter int BAD_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] fa_in,
  input  logic [FRAME_BITS-1:0] fb_in,
  input  logic [STEAL_W-1:0]    steal_in,
  input  logic [BAD_W-1:0]      bad_in,
  output logic [FRAME_BITS-1:0] fa_q,
  output logic [FRAME_BITS-1:0] fb_q,
  output logic [STEAL_W-1:0]    steal_q,
  output logic [BAD_W-1:0]      bad_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fa_q    <= '0;
      fb_q    <= '0;
      steal_q <= '0;
      bad_q   <= '0;
    end else if (load) begin
      fa_q    <= fa_in;
      fb_q    <= fb_in;
      steal_q <= steal_in;
      bad_q   <= bad_in;
    end
  end

  // R9: captured block contents move only on a block start
  assert_hold_inputs_R9: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(fa_q) && $stable(fb_q) && $stable(steal_q) && $stable(bad_q)));
endmodule

// File: rtl/sblk_pick.sv
module sblk_pick
  import sblk_pkg::*;
#(
  parameter int FRAME_BITS = 137,
  parameter int SPARE_BITS = 79,
  parameter int CTRL_BITS  = 5,
  localparam int PAY_SLOTS = 2 * (FRAME_BITS + SPARE_BITS),
  localparam int SLOT_W    = $clog2(PAY_SLOTS),
  localparam int FI_W      = $clog2(FRAME_BITS),
  localparam int CI_W      = $clog2(CTRL_BITS)
) (
  input  bitkind_e              kind,
  input  logic [CI_W-1:0]       ctrl_idx,
  input  logic [SLOT_W-1:0]     slot,
  input  logic [FRAME_BITS-1:0] fa,
  input  logic [FRAME_BITS-1:0] fb,
  input  logic [2:0]            steal,
  input  logic [1:0]            bad,
  output logic                  bit_o
);
  localparam int HALF = FRAME_BITS + SPARE_BITS;

  logic [CTRL_BITS-1:0] cw;
  logic [FI_W-1:0]      ia;
  logic [FI_W-1:0]      ib;
  logic                 pay_bit;

  // control word in send order: steal code MSB first, then the two bad flags
  assign cw = {bad[0], bad[1], steal[0], steal[1], steal[2]};
  assign ia = FI_W'(slot);
  assign ib = FI_W'(slot - SLOT_W'(HALF));

  always_comb begin
    if (slot < SLOT_W'(FRAME_BITS))
      pay_bit = fa[ia];
    else if (slot < SLOT_W'(HALF))
      pay_bit = 1'b1;
    else if (slot < SLOT_W'(HALF + FRAME_BITS))
      pay_bit = fb[ib];
    else
      pay_bit = 1'b1;
  end

  always_comb begin
    unique case (kind)
      BK_HDR0: bit_o = 1'b0;
      BK_HDR1: bit_o = 1'b1;
      BK_CTRL: bit_o = cw[ctrl_idx];
      BK_SYNC: bit_o = 1'b1;
      default: bit_o = pay_bit;
    endcase
  end
endmodule

// File: rtl/sblk_framer.sv
module sblk_framer
  import sblk_pkg::*;
#(
  parameter int BLOCK_BITS  = 480,
  parameter int FRAME_BITS  = 137,
  parameter int SPARE_BITS  = 79,
  parameter int HDR_ZEROS   = 24,
  parameter int SYNC_PERIOD = 24,
  parameter int CTRL_BITS   = 5,
  localparam int PAY_SLOTS  = 2 * (FRAME_BITS + SPARE_BITS),
  localparam int SLOT_W     = $clog2(PAY_SLOTS),
  localparam int CI_W       = $clog2(CTRL_BITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_en,
  input  logic                  call_active,
  input  logic [FRAME_BITS-1:0] frame_a,
  input  logic [FRAME_BITS-1:0] frame_b,
  input  logic [2:0]            steal_code,
  input  logic [1:0]            bad_code,
  output logic                  ser_out,
  output logic                  block_start
);
  logic              start, emit, in_block, nxt_bit;
  bitkind_e          kind;
  logic [CI_W-1:0]   ctrl_idx;
  logic [SLOT_W-1:0] slot;
  logic [FRAME_BITS-1:0] fa_q, fb_q;
  logic [2:0]        steal_q;
  logic [1:0]        bad_q;

  sblk_seq #(
    .BLOCK_BITS(BLOCK_BITS), .HDR_ZEROS(HDR_ZEROS), .CTRL_BITS(CTRL_BITS),
    .SYNC_PERIOD(SYNC_PERIOD), .FRAME_BITS(FRAME_BITS), .SPARE_BITS(SPARE_BITS)
  ) u_seq (
    .clk(clk), .rst(rst), .en(bit_en), .call_active(call_active),
    .start(start), .emit(emit), .in_block(in_block), .kind(kind),
    .ctrl_idx(ctrl_idx), .slot(slot)
  );

  sblk_hold #(.FRAME_BITS(FRAME_BITS), .STEAL_W(3), .BAD_W(2)) u_hold (
    .clk(clk), .rst(rst), .load(start),
    .fa_in(frame_a), .fb_in(frame_b), .steal_in(steal_code), .bad_in(bad_code),
    .fa_q(fa_q), .fb_q(fb_q), .steal_q(steal_q), .bad_q(bad_q)
  );

  sblk_pick #(
    .FRAME_BITS(FRAME_BITS), .SPARE_BITS(SPARE_BITS), .CTRL_BITS(CTRL_BITS)
  ) u_pick (
    .kind(kind), .ctrl_idx(ctrl_idx), .slot(slot),
    .fa(fa_q), .fb(fb_q), .steal(steal_q), .bad(bad_q), .bit_o(nxt_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out     <= 1'b1;
      block_start <= 1'b0;
    end else begin
      block_start <= start;
      if (bit_en)
        ser_out <= emit ? nxt_bit : 1'b1;
    end
  end

  // R1: an idle enable with no call leaves a one on the line
  assert_idle_ones_R1: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !in_block && !call_active) |=> ser_out);

  // R11: the line moves only on enable edges
  assert_hold_line_R11: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(ser_out));

  // R10: the start marker always accompanies a header zero
  assert_mark_zero_R10: assert property (@(posedge clk) disable iff (rst)
    block_start |-> !ser_out);

  // R5: forced positions reach the line as ones
  assert_sync_one_R5: assert property (@(posedge clk) disable iff (rst)
    (emit && kind == BK_SYNC) |=> ser_out);

  // R3: header zero positions reach the line as zeros
  assert_header_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (emit && kind == BK_HDR0) |=> !ser_out);
endmodule

// File: tb/sim_sblk_framer.sv
module sim_sblk_framer;
  localparam int FB = 137;
  localparam int NB = 480;
  localparam int NV = 6;
  // {steal, bad, seed_a, seed_b}
  localparam logic [68:0] VEC [0:NV-1] = '{
    {3'b000, 2'b00, 32'h0000_0001, 32'h0000_0002},
    {3'b011, 2'b01, 32'h0000_0000, 32'h0000_0000},
    {3'b100, 2'b10, 32'hDEAD_BEEF, 32'h0001_2345},
    {3'b111, 2'b11, 32'h0000_A5A5, 32'h0000_5A5A},
    {3'b101, 2'b00, 32'h0000_0077, 32'h0000_0099},
    {3'b110, 2'b01, 32'hFFFF_0001, 32'h0000_003C}
  };

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, call = 1'b0;
  logic [FB-1:0] fa = '0, fb = '0;
  logic [2:0] steal = '0;
  logic [1:0] bad = '0;
  logic ser, bst;

  int total = 0, bad_cnt = 0, hold_err = 0;
  logic en_seen = 1'b0, rst_seen = 1'b1, last_ser = 1'b1;
  logic exp_bit [0:NB-1];
  int   exp_cat [0:NB-1];
  logic got [0:NB-1];
  int   mark_err;
  bit   done = 1'b0;

  sblk_framer u0 (
    .clk(clk), .rst(rst), .bit_en(en), .call_active(call),
    .frame_a(fa), .frame_b(fb), .steal_code(steal), .bad_code(bad),
    .ser_out(ser), .block_start(bst)
  );

  always #2 clk = ~clk;

  initial begin
    int ecnt = 0;
    forever begin
      @(negedge clk);
      ecnt = (ecnt == 2) ? 0 : ecnt + 1;
      en = (ecnt == 0);
    end
  end

  initial forever begin
    @(posedge clk);
    en_seen = en;
    rst_seen = rst;
  end

  initial forever begin
    @(negedge clk);
    if (!rst_seen && !en_seen && ser !== last_ser) hold_err++;
    last_ser = ser;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad_cnt++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad_cnt);
      $finish;
    end
  end

  function automatic logic [FB-1:0] gen_frame(logic [31:0] seed);
    logic [31:0] x = seed;
    logic [FB-1:0] f;
    for (int i = 0; i < FB; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      f[i] = x[7];
    end
    return f;
  endfunction

  task automatic apply_vec(int v);
    steal = VEC[v][68:66];
    bad   = VEC[v][65:64];
    fa    = gen_frame(VEC[v][63:32]);
    fb    = gen_frame(VEC[v][31:0]);
  endtask

  // expected block built from the stated layout
  task automatic build_exp(logic [FB-1:0] a, logic [FB-1:0] b, logic [2:0] st, logic [1:0] bf);
    int k = 0;
    for (int p = 0; p < NB; p++) begin
      if (p < 24) begin exp_bit[p] = 1'b0; exp_cat[p] = 0; end
      else if (p == 24) begin exp_bit[p] = 1'b1; exp_cat[p] = 0; end
      else if (p < 30) begin
        exp_cat[p] = 1;
        case (p)
          25: exp_bit[p] = st[2];
          26: exp_bit[p] = st[1];
          27: exp_bit[p] = st[0];
          28: exp_bit[p] = bf[1];
          default: exp_bit[p] = bf[0];
        endcase
      end else if (p >= 48 && (p - 48) % 24 == 0) begin exp_bit[p] = 1'b1; exp_cat[p] = 2; end
      else begin
        if (k < 137) begin exp_bit[p] = a[k]; exp_cat[p] = 3; end
        else if (k < 216) begin exp_bit[p] = 1'b1; exp_cat[p] = 4; end
        else if (k < 353) begin exp_bit[p] = b[k - 216]; exp_cat[p] = 5; end
        else begin exp_bit[p] = 1'b1; exp_cat[p] = 6; end
        k++;
      end
    end
  endtask

  task automatic step_bit(output logic b, output logic s);
    forever begin
      @(posedge clk);
      if (en) break;
    end
    #1;
    b = ser; s = bst;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mid: bit index at which the hook runs; hook 0 none, 1 next vector, 2 garbage and drop call
  task automatic collect(output int waits, input int mid, input int hook, input int nxt);
    logic b, s;
    waits = 0; mark_err = 0;
    step_bit(b, s);
    while (!s && waits < 2000) begin waits++; step_bit(b, s); end
    got[0] = b;
    @(posedge clk); #1;
    if (bst !== 1'b0) mark_err++;
    for (int p = 1; p < NB; p++) begin
      step_bit(b, s);
      got[p] = b;
      if (s) mark_err++;
      if (p == mid) begin
        if (hook == 1) apply_vec(nxt);
        if (hook == 2) begin fa = '1; fb = '1; steal = 3'b111; bad = 2'b11; call = 1'b0; end
      end
    end
  endtask

  task automatic judge();
    string nm [0:6] = '{"R3 header", "R4 control", "R5 sync", "R6 R9 frame1",
                        "R7 spare1", "R8 R9 frame2", "R7 spare2"};
    for (int c = 0; c < 7; c++) begin
      int first = -1;
      for (int p = 0; p < NB; p++)
        if (exp_cat[p] == c && got[p] !== exp_bit[p] && first < 0) first = p;
      if (first < 0) check(1'b1, nm[c], 0, 0);
      else begin
        total++; bad_cnt++;
        $display("FAIL %s at bit %0d: actual=%0b expected=%0b", nm[c], first, got[first], exp_bit[first]);
      end
    end
    check(mark_err == 0, "R10 marker width", mark_err, 0);
  endtask

  initial begin
    logic b, s;
    int waits, ones;
    logic [FB-1:0] ea, eb;
    logic [2:0] est;
    logic [1:0] ebd;

    repeat (5) @(posedge clk);
    #1;
    check(ser === 1'b1 && bst === 1'b0, "R1 reset state", {ser, bst}, 2);
    rst = 1'b0;

    // R1: idle line
    ones = 0;
    for (int i = 0; i < 30; i++) begin step_bit(b, s); if (b === 1'b1 && !s) ones++; end
    check(ones == 30, "R1 idle ones", ones, 30);

    // table walk: back-to-back blocks, next inputs loaded mid-block (R9, R12)
    apply_vec(0);
    call = 1'b1;
    for (int v = 0; v < NV; v++) begin
      ea = fa; eb = fb; est = steal; ebd = bad;
      build_exp(ea, eb, est, ebd);
      collect(waits, 200, (v == NV - 1) ? 2 : 1, (v == NV - 1) ? 0 : v + 1);
      judge();
      if (v > 0) check(waits == 0, "R12 no idle gap", waits, 0);
    end

    // R2: last block ran to 480 bits after call dropped; then line idles
    ones = 0;
    for (int i = 0; i < 40; i++) begin step_bit(b, s); if (b === 1'b1 && !s) ones++; end
    check(ones == 40, "R2 R1 idle after drop", ones, 40);

    // reset in mid-block returns the line to idle
    apply_vec(2);
    call = 1'b1;
    step_bit(b, s);
    while (!s) step_bit(b, s);
    for (int i = 0; i < 50; i++) step_bit(b, s);
    @(posedge clk); #1; rst = 1'b1; call = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(ser === 1'b1 && bst === 1'b0, "R1 reset mid-block", ser, 1);
    rst = 1'b0;
    ones = 0;
    for (int i = 0; i < 10; i++) begin step_bit(b, s); if (b === 1'b1 && !s) ones++; end
    check(ones == 10, "R1 idle after reset", ones, 10);

    check(hold_err == 0, "R11 line held between enables", hold_err, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad_cnt);
    $finish;
  end
endmodule